// File: doc/BRIEF.md
# Priority Pin Crossbar Decoder

This block connects a fixed, ranked set of internal peripheral signals to a bank of general I/O pins. The default bank is four 8-bit ports, 32 pins in all. Software sets per-peripheral enable bits in three configuration words. It also marks pins to keep out of the crossbar with a skip mask and sets one global crossbar enable. From these inputs the block works out combinationally which signal owns each pin. Enabled peripherals are taken in rank order, and each signal takes the lowest-numbered pin that is neither skipped nor already taken. The top-ranked serial port is the exception: its transmit and receive lines always sit on two fixed pins, and those pins are reserved before any other signal is placed.

Pins that no peripheral owns act as general-purpose outputs. They drive their latch value and output-enable. Owned pins carry the peripheral's data and enable. Each placed peripheral input receives the level of its pin. A port read always returns the raw pin level. While the crossbar is disabled, no pin drives. A registered copy of the per-pin owner table follows the configuration one clock later. A status bit reports when an enabled group ran out of pins.

Top module: `pin_crossbar`

## Requirements
- R1: When the top serial port is enabled (cfg_a bit 0), its transmit line (code 1) owns pin U0_TX_PIN (default 4) and its receive line (code 2) owns pin U0_RX_PIN (default 5), whatever the skip bits of those pins.
- R2: Owner codes per pin are 0 for GPIO and k for signal k. The signals, in priority order, are: 1 TX0, 2 RX0, 3 SCK, 4 MISO, 5 MOSI, 6 NSS, 7 SDA, 8 SCL, 9 CMP0, 10 CMP1, 11 SYSCLK, 12 T0IN, 13 T1IN, 14 TX1, 15 RX1. Group enables are cfg_a bits 0..5 (top serial port, SPI, SMBus, CMP0, CMP1, SYSCLK), cfg_b bits 0..1 (T0IN, T1IN) and cfg_c bit 0 (second serial port). The signals of every enabled group except the top serial port are placed in code order. Each takes the lowest pin that is not skipped, not reserved and not yet taken.
- R3: A pin whose skip_mask bit is 1 never receives a signal with a code of 3 or higher. It reads as code 0 unless R1 fixes it.
- R4: When the top serial port is disabled, its two fixed pins are free for other signals.
- R5: If pins run out, the signals already placed keep their pins and the remaining signals are left out. A left-out signal's periph_in bit is 0. alloc_ovf is 1 exactly when some enabled signal was left out.
- R6: While xbar_en is 0, pin_oe is all zeros, GPIO pins included, and every periph_in bit is 0.
- R7: port_rd always equals pin_in.
- R8: With xbar_en at 1, a code-0 pin drives gpio_latch on pin_out and gpio_oe on pin_oe.
- R9: With xbar_en at 1, a pin owned by signal k drives periph_out[k-1] and periph_oe[k-1], and periph_in[k-1] takes that pin's level.
- R10: pin_sel_q resets to all zeros. Afterwards it holds the owner table sampled at the previous rising clock edge, with pin p in bits [4p+3:4p].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_a | input | 6 | Group enables: top serial port, SPI, SMBus, CMP0, CMP1, SYSCLK |
| cfg_b | input | 2 | Group enables: timer 0 input, timer 1 input |
| cfg_c | input | 1 | Group enable: second serial port |
| xbar_en | input | 1 | Global crossbar enable |
| skip_mask | input | 32 | Pins withheld from the crossbar |
| gpio_latch | input | 32 | Port latch values for GPIO pins |
| gpio_oe | input | 32 | Output enables for GPIO pins |
| periph_out | input | 15 | Peripheral output data, bit k-1 for code k |
| periph_oe | input | 15 | Peripheral output enables, bit k-1 for code k |
| periph_in | output | 15 | Pin levels returned to the placed peripheral signals |
| pin_in | input | 32 | Pad input levels |
| pin_out | output | 32 | Pad output data |
| pin_oe | output | 32 | Pad output enables |
| port_rd | output | 32 | Raw pin levels for port reads |
| pin_sel_q | output | 128 | Registered owner code per pin, 4 bits each |
| alloc_ovf | output | 1 | An enabled signal found no free pin |

## Verification
The bench keeps the default build: four ports of eight pins, with the fixed serial pins at 4 and 5. With 32 pins and 13 movable signals, a full enable fills the low pins around the reserved pair. A skip mask that leaves only the top two pins free sends the second serial port to pins 30 and 31, which checks the search at the top of the bank. Leaving three pins free forces a group to be split part-way, which checks the overflow rules.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  // Number of crossbar signals and peripheral groups (fixed by the signal list)
  localparam int NSIG   = 15;
  localparam int NGRP   = 9;
  localparam int CODE_W = $clog2(NSIG + 1);

  localparam logic [CODE_W-1:0] CODE_GPIO = '0;

  // Group indices, highest priority first
  localparam int G_UART0  = 0;
  localparam int G_SPI    = 1;
  localparam int G_SMB    = 2;
  localparam int G_CMP0   = 3;
  localparam int G_CMP1   = 4;
  localparam int G_SYSCLK = 5;
  localparam int G_T0     = 6;
  localparam int G_T1     = 7;
  localparam int G_UART1  = 8;

  // Signal index (code - 1) to owning group
  function automatic int sig_group(input int s);
    case (s)
      0, 1:        return G_UART0;
      2, 3, 4, 5:  return G_SPI;
      6, 7:        return G_SMB;
      8:           return G_CMP0;
      9:           return G_CMP1;
      10:          return G_SYSCLK;
      11:          return G_T0;
      12:          return G_T1;
      default:     return G_UART1;
    endcase
  endfunction

  // Owner code carried by signal index s
  function automatic logic [CODE_W-1:0] code_of(input int s);
    return CODE_W'(s + 1);
  endfunction

endpackage

// File: rtl/xbar_cfg_decode.sv
module xbar_cfg_decode
  import xbar_pkg::*;
(
  input  logic [5:0]      cfg_a,
  input  logic [1:0]      cfg_b,
  input  logic [0:0]      cfg_c,
  output logic [NSIG-1:0] sig_en
);

  logic [NGRP-1:0] grp_en;

  // Group enable vector in priority order
  assign grp_en = {cfg_c[0], cfg_b, cfg_a};

  // Each signal inherits the enable of its group
  for (genvar s = 0; s < NSIG; s++) begin : g_sig
    assign sig_en[s] = grp_en[sig_group(s)];
  end

endmodule

// File: rtl/xbar_alloc.sv
module xbar_alloc
  import xbar_pkg::*;
#(
  parameter  int NPINS  = 32,
  parameter  int TX_PIN = 4,
  parameter  int RX_PIN = 5,
  localparam int IDX_W  = $clog2(NPINS)
) (
  input  logic [NSIG-1:0]              sig_en,
  input  logic [NPINS-1:0]             skip,
  output logic [NPINS-1:0][CODE_W-1:0] pin_code,
  output logic [NSIG-1:0][IDX_W-1:0]   sig_pin,
  output logic [NSIG-1:0]              sig_placed,
  output logic                         ovf
);

  localparam logic [NPINS-1:0] FIXED_MASK =
    (NPINS'(1) << TX_PIN) | (NPINS'(1) << RX_PIN);

  // Isolate the lowest set bit
  function automatic logic [NPINS-1:0] lowest_onehot(input logic [NPINS-1:0] v);
    return v & (~v + NPINS'(1));
  endfunction

  // One-hot to index
  function automatic logic [IDX_W-1:0] onehot_idx(input logic [NPINS-1:0] oh);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (oh[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  // Free-pin chain through the movable signals (index 2 upward)
  logic [NPINS-1:0] avail [2:NSIG-1];
  logic [NPINS-1:0] grab  [NSIG];

  assign avail[2] = ~skip & ~(sig_en[0] ? FIXED_MASK : '0);

  for (genvar s = 0; s < NSIG; s++) begin : g_sig
    if (s == 0) begin : g_tx
      assign grab[s] = sig_en[s] ? (NPINS'(1) << TX_PIN) : '0;
    end else if (s == 1) begin : g_rx
      assign grab[s] = sig_en[s] ? (NPINS'(1) << RX_PIN) : '0;
    end else begin : g_flow
      assign grab[s] = sig_en[s] ? lowest_onehot(avail[s]) : '0;
      if (s < NSIG - 1) begin : g_next
        assign avail[s+1] = avail[s] & ~grab[s];
      end
    end
    assign sig_placed[s] = |grab[s];
    assign sig_pin[s]    = onehot_idx(grab[s]);
  end

  assign ovf = |(sig_en & ~sig_placed);

  // Per-pin owner table
  always_comb begin
    pin_code = '0;
    for (int s = 0; s < NSIG; s++) begin
      for (int p = 0; p < NPINS; p++) begin
        if (grab[s][p]) pin_code[p] = code_of(s);
      end
    end
  end

endmodule

// File: rtl/xbar_route.sv
module xbar_route
  import xbar_pkg::*;
#(
  parameter  int NPINS = 32,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic                         xbar_en,
  input  logic [NPINS-1:0][CODE_W-1:0] pin_code,
  input  logic [NSIG-1:0][IDX_W-1:0]   sig_pin,
  input  logic [NSIG-1:0]              sig_placed,
  input  logic [NSIG-1:0]              periph_out,
  input  logic [NSIG-1:0]              periph_oe,
  input  logic [NPINS-1:0]             gpio_latch,
  input  logic [NPINS-1:0]             gpio_oe,
  input  logic [NPINS-1:0]             pin_in,
  output logic [NPINS-1:0]             pin_out,
  output logic [NPINS-1:0]             pin_oe,
  output logic [NSIG-1:0]              periph_in,
  output logic [NPINS-1:0]             port_rd
);

  // Outbound: pin driven by its owner or by the port latch
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic              is_gpio;
    logic [CODE_W-1:0] sidx;
    assign is_gpio    = (pin_code[p] == CODE_GPIO);
    assign sidx       = is_gpio ? '0 : pin_code[p] - 1'b1;
    assign pin_out[p] = xbar_en & (is_gpio ? gpio_latch[p] : periph_out[sidx]);
    assign pin_oe[p]  = xbar_en & (is_gpio ? gpio_oe[p]    : periph_oe[sidx]);
  end

  // Inbound: each placed signal sees its pin
  for (genvar s = 0; s < NSIG; s++) begin : g_in
    assign periph_in[s] = xbar_en & sig_placed[s] & pin_in[sig_pin[s]];
  end

  assign port_rd = pin_in;

endmodule

// File: rtl/pin_crossbar.sv
module pin_crossbar
  import xbar_pkg::*;
#(
  parameter  int NUM_PORTS = 4,
  parameter  int PORT_W    = 8,
  parameter  int U0_TX_PIN = 4,
  parameter  int U0_RX_PIN = 5,
  localparam int NPINS     = NUM_PORTS * PORT_W,
  localparam int IDX_W     = $clog2(NPINS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [5:0]              cfg_a,
  input  logic [1:0]              cfg_b,
  input  logic [0:0]              cfg_c,
  input  logic                    xbar_en,
  input  logic [NPINS-1:0]        skip_mask,
  input  logic [NPINS-1:0]        gpio_latch,
  input  logic [NPINS-1:0]        gpio_oe,
  input  logic [NSIG-1:0]         periph_out,
  input  logic [NSIG-1:0]         periph_oe,
  output logic [NSIG-1:0]         periph_in,
  input  logic [NPINS-1:0]        pin_in,
  output logic [NPINS-1:0]        pin_out,
  output logic [NPINS-1:0]        pin_oe,
  output logic [NPINS-1:0]        port_rd,
  output logic [NPINS*CODE_W-1:0] pin_sel_q,
  output logic                    alloc_ovf
);

  // Named internal events for the checker
  logic [NSIG-1:0]              sig_en_w;
  logic [NSIG-1:0]              sig_placed_w;
  logic [NSIG-1:0][IDX_W-1:0]   sig_pin_w;
  logic [NPINS-1:0][CODE_W-1:0] pin_code_w;

  xbar_cfg_decode u_dec (
    .cfg_a  (cfg_a),
    .cfg_b  (cfg_b),
    .cfg_c  (cfg_c),
    .sig_en (sig_en_w)
  );

  xbar_alloc #(
    .NPINS  (NPINS),
    .TX_PIN (U0_TX_PIN),
    .RX_PIN (U0_RX_PIN)
  ) u_alloc (
    .sig_en     (sig_en_w),
    .skip       (skip_mask),
    .pin_code   (pin_code_w),
    .sig_pin    (sig_pin_w),
    .sig_placed (sig_placed_w),
    .ovf        (alloc_ovf)
  );

  xbar_route #(
    .NPINS (NPINS)
  ) u_route (
    .xbar_en    (xbar_en),
    .pin_code   (pin_code_w),
    .sig_pin    (sig_pin_w),
    .sig_placed (sig_placed_w),
    .periph_out (periph_out),
    .periph_oe  (periph_oe),
    .gpio_latch (gpio_latch),
    .gpio_oe    (gpio_oe),
    .pin_in     (pin_in),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .periph_in  (periph_in),
    .port_rd    (port_rd)
  );

  // Registered owner table, one cycle behind the configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_sel_q <= '0;
    else        pin_sel_q <= pin_code_w;
  end

endmodule

// File: rtl/pin_crossbar_chk.sv
module pin_crossbar_chk
  import xbar_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int TX_PIN = 4,
  parameter int RX_PIN = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    xbar_en,
  input logic [NPINS-1:0]        skip_mask,
  input logic [NPINS-1:0]        pin_in,
  input logic [NPINS-1:0]        pin_oe,
  input logic [NPINS-1:0]        port_rd,
  input logic [NPINS*CODE_W-1:0] pin_sel_q,
  input logic                    alloc_ovf,
  input logic [NSIG-1:0]         sig_en,
  input logic [NSIG-1:0]         sig_placed,
  input logic [NPINS*CODE_W-1:0] pin_code
);

  assert_uart0_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sig_en[0] |-> (pin_code[TX_PIN*CODE_W +: CODE_W] == CODE_W'(1)) &&
                  (pin_code[RX_PIN*CODE_W +: CODE_W] == CODE_W'(2)))
    else $error("uart0 not on fixed pins");

  for (genvar p = 0; p < NPINS; p++) begin : g_skip
    localparam bit FIXED = (p == TX_PIN) || (p == RX_PIN);
    assert_skip_gpio_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (skip_mask[p] && !(FIXED && sig_en[0])) |-> (pin_code[p*CODE_W +: CODE_W] == CODE_GPIO))
      else $error("skipped pin %0d allocated", p);
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_ovf |-> ($countones(sig_placed) == $countones(sig_en)))
    else $error("missing placement without overflow flag");

  assert_drivers_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !xbar_en |-> (pin_oe == '0))
    else $error("pin driving while crossbar off");

  assert_port_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    port_rd == pin_in)
    else $error("port read differs from pin");

  assert_sel_reg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (pin_sel_q == $past(pin_code)))
    else $error("registered table lags");

endmodule

bind pin_crossbar pin_crossbar_chk #(
  .NPINS  (NPINS),
  .TX_PIN (U0_TX_PIN),
  .RX_PIN (U0_RX_PIN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xbar_en    (xbar_en),
  .skip_mask  (skip_mask),
  .pin_in     (pin_in),
  .pin_oe     (pin_oe),
  .port_rd    (port_rd),
  .pin_sel_q  (pin_sel_q),
  .alloc_ovf  (alloc_ovf),
  .sig_en     (sig_en_w),
  .sig_placed (sig_placed_w),
  .pin_code   (pin_code_w)
);

// File: tb/sim_pin_crossbar.sv
module sim_pin_crossbar;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;
  localparam int NS = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    cfg_a = '0;
  logic [1:0]    cfg_b = '0;
  logic [0:0]    cfg_c = '0;
  logic          xbar_en = 1'b0;
  logic [NP-1:0] skip_mask = '0;
  logic [NP-1:0] gpio_latch = '0;
  logic [NP-1:0] gpio_oe = '0;
  logic [NS-1:0] periph_out = '0;
  logic [NS-1:0] periph_oe = '0;
  logic [NS-1:0] periph_in;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;
  logic [NP-1:0] port_rd;
  logic [NP*4-1:0] pin_sel_q;
  logic          alloc_ovf;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Scoreboard of expected registered tables
  logic [NP*4-1:0] q_sel [$];
  string           q_tag [$];

  logic [3:0] exp_code [NP];
  bit         exp_ovf;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_crossbar u0 (
    .clk(clk), .rst_n(rst_n), .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_c(cfg_c),
    .xbar_en(xbar_en), .skip_mask(skip_mask), .gpio_latch(gpio_latch),
    .gpio_oe(gpio_oe), .periph_out(periph_out), .periph_oe(periph_oe),
    .periph_in(periph_in), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .port_rd(port_rd), .pin_sel_q(pin_sel_q), .alloc_ovf(alloc_ovf)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit grp_on(input int code);
    if (code <= 2)  return cfg_a[0];
    if (code <= 6)  return cfg_a[1];
    if (code <= 8)  return cfg_a[2];
    if (code == 9)  return cfg_a[3];
    if (code == 10) return cfg_a[4];
    if (code == 11) return cfg_a[5];
    if (code == 12) return cfg_b[0];
    if (code == 13) return cfg_b[1];
    return cfg_c[0];
  endfunction

  // Pin-walk model: hand the next pending signal to each free pin in turn
  task automatic build_model();
    int pend [$];
    for (int k = 3; k <= 15; k++) if (grp_on(k)) pend.push_back(k);
    for (int p = 0; p < NP; p++) begin
      if (cfg_a[0] && p == 4)       exp_code[p] = 4'd1;
      else if (cfg_a[0] && p == 5)  exp_code[p] = 4'd2;
      else if (skip_mask[p])        exp_code[p] = 4'd0;
      else if (pend.size() > 0)     exp_code[p] = 4'(pend.pop_front());
      else                          exp_code[p] = 4'd0;
    end
    exp_ovf = (pend.size() > 0);
  endtask

  function automatic logic [NP*4-1:0] flat_exp();
    logic [NP*4-1:0] f;
    for (int p = 0; p < NP; p++) f[p*4 +: 4] = exp_code[p];
    return f;
  endfunction

  task automatic apply(input logic [5:0] a, input logic [1:0] b, input logic [0:0] c,
                       input logic en, input logic [NP-1:0] skip, input string tag);
    logic [NP-1:0] eo, eoe;
    logic [NS-1:0] epi;
    @(negedge clk);
    cfg_a = a; cfg_b = b; cfg_c = c; xbar_en = en; skip_mask = skip;
    pin_in = $urandom; gpio_latch = $urandom; gpio_oe = $urandom;
    periph_out = NS'($urandom); periph_oe = NS'($urandom);
    #1;
    build_model();
    epi = '0;
    for (int p = 0; p < NP; p++) begin
      if (!en) begin eo[p] = 1'b0; eoe[p] = 1'b0; end
      else if (exp_code[p] == 0) begin eo[p] = gpio_latch[p]; eoe[p] = gpio_oe[p]; end
      else begin
        eo[p] = periph_out[exp_code[p]-1];
        eoe[p] = periph_oe[exp_code[p]-1];
        epi[exp_code[p]-1] = pin_in[p] & en;
      end
    end
    // R5: overflow flag
    check(alloc_ovf == exp_ovf, "R5", {tag, " ovf"}, 128'(alloc_ovf), 128'(exp_ovf));
    // R8 / R9 / R6: pad drive
    check(pin_out == eo && pin_oe == eoe, "R8_R9", {tag, " drive"},
          {pin_out, pin_oe}, {eo, eoe});
    // R9 / R5: inbound, left-out signals read 0
    check(periph_in == epi, "R9", {tag, " periph_in"}, 128'(periph_in), 128'(epi));
    // R7: raw read
    check(port_rd == pin_in, "R7", {tag, " port_rd"}, 128'(port_rd), 128'(pin_in));
    @(posedge clk);
    #1;
    q_sel.push_back(flat_exp());
    q_tag.push_back(tag);
  endtask

  // Monitor: compares registered table on the falling edge after each update
  initial begin
    forever begin
      @(negedge clk);
      if (q_sel.size() > 0) begin
        logic [NP*4-1:0] e;
        string t;
        e = q_sel.pop_front();
        t = q_tag.pop_front();
        check(pin_sel_q == e, "R10", {t, " pin_sel_q"}, pin_sel_q, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state, R6 drivers off
    check(pin_sel_q == '0, "R10", "reset table", pin_sel_q, '0);
    check(pin_oe == '0, "R6", "reset drivers", 128'(pin_oe), '0);
    @(negedge clk); rst_n = 1'b1;

    // R1 fixed pins
    apply(6'b000001, 2'b00, 1'b0, 1'b1, '0, "R1 uart0 only");
    // R2 SPI around reserved pins
    apply(6'b000011, 2'b00, 1'b0, 1'b1, '0, "R2 uart0+spi");
    // R3 skips, R1 fixed pins ignore skip
    apply(6'b000111, 2'b00, 1'b0, 1'b1, 32'h0000_0035, "R3 skip 0,2,4,5");
    // R4 fixed pins free when top port off
    apply(6'b001010, 2'b00, 1'b0, 1'b1, '0, "R4 spi+cmp0");
    // R2 everything enabled
    apply(6'b111111, 2'b11, 1'b1, 1'b1, '0, "R2 all groups");
    // R5 overflow split inside a group
    apply(6'b000111, 2'b00, 1'b0, 1'b1, 32'hFFFF_FFF8, "R5 three free");
    // R2 allocation at top of bank
    apply(6'b000000, 2'b00, 1'b1, 1'b1, 32'h3FFF_FFFF, "R2 uart1 high");
    // R6 drivers off with everything on
    apply(6'b111111, 2'b11, 1'b1, 1'b0, '0, "R6 crossbar off");
    // R8 pure GPIO
    apply(6'b000000, 2'b00, 1'b0, 1'b1, '0, "R8 gpio only");
    // R5 timer inputs with nothing left
    apply(6'b000001, 2'b11, 1'b0, 1'b1, 32'hFFFF_FFFF, "R5 all skipped");
    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule